// File: doc/BRIEF.md
# Receive Descriptor Writeback Engine

This block sits behind a receive MAC and turns an incoming frame, delivered as a stream of byte beats with start and end markers, into a sequence of descriptor writeback records, one per fixed-size receive buffer. When the current buffer fills, or when the frame ends, it emits a record. The record holds the byte count of that buffer, a packet checksum, an 8-bit status byte and an error byte. The checksum value, the error byte and the checksum flags are computed upstream. They arrive as sideband inputs that are valid together with the frame's last beat. The block folds them into the final record only.

The buffer size, the VLAN ethertype to compare against and the VLAN enable bit are static configuration inputs. The writeback output uses a valid/ready handshake. While a record is waiting to be accepted, the byte stream is held off through `in_ready`. Non-final records carry only a length and the done flag. Status, error and checksum are meaningful only in the record that closes the frame.

Top module: `rx_wb_engine`

## Requirements
- R1: When a buffer fills before the frame ends, a record is emitted with `wb_len` equal to `cfg_buf_size` and status bit 1 (end of packet) clear.
- R2: The last beat of a frame (`in_eop`) always closes a record whose `wb_len` counts every beat accepted into that buffer, trailing CRC beats included, and whose status bit 1 is set.
- R3: A frame whose length is an exact multiple of the buffer size produces no zero-length record: its final full buffer carries status bit 1. No record ever has `wb_len` equal to 0.
- R4: Status bit 0 (done) is set in every record emitted.
- R5: In a record with status bit 1 clear, status bits 7..2, `wb_err` and `wb_csum` are all zero.
- R6: In a final record, status bit 3 is 1 exactly when `cfg_vlan_en` is 1 and `sb_frame_type` equals `cfg_vlan_type`.
- R7: In a final record, status bit 2 copies `sb_ixsm`. When it is 1, bits 6 and 5 are 0. When it is 0, bit 6 copies `sb_ipcs` and bit 5 copies `sb_tcpcs`. Bit 7 copies `sb_pif`, and bit 4 is always 0.
- R8: A final record carries `sb_err` in `wb_err` and `sb_csum` in `wb_csum`, as sampled on the accepted last beat.
- R9: While `wb_valid` is 1 and `wb_ready` is 0, the record stays unchanged and `in_ready` is 0.
- R10: A beat with `in_sop` set starts a new buffer count at 1. Beats of an unterminated earlier frame are discarded without a record.
- R11: After reset, `wb_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_buf_size | input | LEN_W | Receive buffer size in bytes (at least 1) |
| cfg_vlan_type | input | TYPE_W | VLAN ethertype to compare against |
| cfg_vlan_en | input | 1 | VLAN mode enable |
| in_valid | input | 1 | A byte beat is offered |
| in_ready | output | 1 | The beat is accepted this cycle |
| in_sop | input | 1 | Beat is the first of a frame |
| in_eop | input | 1 | Beat is the last of a frame |
| sb_frame_type | input | TYPE_W | Frame type field, valid with the last beat |
| sb_ixsm | input | 1 | Ignore-checksum indication, valid with the last beat |
| sb_ipcs | input | 1 | IPv4 checksum was computed |
| sb_tcpcs | input | 1 | TCP/UDP checksum was computed |
| sb_pif | input | 1 | Frame passed an inexact address filter |
| sb_err | input | ERR_W | Error byte for the frame |
| sb_csum | input | CSUM_W | Packet checksum for the frame |
| wb_valid | output | 1 | A writeback record is offered |
| wb_ready | input | 1 | Consumer accepts the record |
| wb_len | output | LEN_W | Bytes written to this buffer |
| wb_csum | output | CSUM_W | Packet checksum (final record only) |
| wb_status | output | 8 | Status byte |
| wb_err | output | ERR_W | Error byte (final record only) |

## Verification
The hardest case to reach from the ports is a buffer that closes while the next beat of the same frame is already waiting. The record must then hold still and the pending beat must be refused until the consumer accepts. The bench sets this up by holding `wb_ready` low during a three-beat frame with a two-byte buffer, checking the held record and `in_ready` for several cycles, then releasing the output and confirming that the remaining beat lands in its own final record. The restart on a start marker is reached by sending a partial frame with no end beat, followed by a complete one.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;

    // Status byte, most significant field first (bit 7 .. bit 0).
    typedef struct packed {
        logic pif;    // bit 7
        logic ipcs;   // bit 6
        logic tcpcs;  // bit 5
        logic rsvd;   // bit 4, always zero
        logic vp;     // bit 3
        logic ixsm;   // bit 2
        logic eop;    // bit 1
        logic dd;     // bit 0
    } rx_stat_t;

    localparam int unsigned STAT_W = $bits(rx_stat_t);

endpackage

// File: rtl/rxwb_fields.sv
module rxwb_fields
    import rxwb_pkg::*;
#(
    parameter int unsigned TYPE_W = 16,
    parameter int unsigned ERR_W  = 8,
    parameter int unsigned CSUM_W = 16
) (
    input  logic              last,
    input  logic [TYPE_W-1:0] frame_type,
    input  logic [TYPE_W-1:0] vlan_type,
    input  logic              vlan_en,
    input  logic              ixsm,
    input  logic              ipcs,
    input  logic              tcpcs,
    input  logic              pif,
    input  logic [ERR_W-1:0]  err_in,
    input  logic [CSUM_W-1:0] csum_in,
    output rx_stat_t          stat,
    output logic [ERR_W-1:0]  err_out,
    output logic [CSUM_W-1:0] csum_out
);

    always_comb begin
        stat      = '0;
        stat.dd   = 1'b1;
        err_out   = '0;
        csum_out  = '0;
        if (last) begin
            stat.eop   = 1'b1;
            stat.ixsm  = ixsm;
            stat.vp    = vlan_en && (frame_type == vlan_type);
            stat.tcpcs = !ixsm && tcpcs;
            stat.ipcs  = !ixsm && ipcs;
            stat.pif   = pif;
            err_out    = err_in;
            csum_out   = csum_in;
        end
    end

endmodule

// File: rtl/rxwb_split.sv
module rxwb_split #(
    parameter int unsigned LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic             sop,
    input  logic             eop,
    input  logic [LEN_W-1:0] buf_size,
    output logic             close,
    output logic [LEN_W-1:0] len
);

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
    } split_t;

    split_t           st_d, st_q;
    logic [LEN_W-1:0] base_d;

    always_comb begin
        st_d   = st_q;
        base_d = sop ? '0 : st_q.cnt;
        len    = base_d + 1'b1;
        close  = acc && (eop || (len >= buf_size));
        if (acc) begin
            st_d.cnt = close ? '0 : len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rxwb_wb_reg.sv
module rxwb_wb_reg
    import rxwb_pkg::*;
#(
    parameter int unsigned LEN_W  = 12,
    parameter int unsigned ERR_W  = 8,
    parameter int unsigned CSUM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LEN_W-1:0]  len_in,
    input  logic [CSUM_W-1:0] csum_in,
    input  rx_stat_t          stat_in,
    input  logic [ERR_W-1:0]  err_in,
    input  logic              ready,
    output logic              busy,
    output logic              valid,
    output logic [LEN_W-1:0]  len,
    output logic [CSUM_W-1:0] csum,
    output rx_stat_t          stat,
    output logic [ERR_W-1:0]  err
);

    typedef struct packed {
        logic              valid;
        logic [LEN_W-1:0]  len;
        logic [CSUM_W-1:0] csum;
        rx_stat_t          stat;
        logic [ERR_W-1:0]  err;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (rec_q.valid && ready) begin
            rec_d.valid = 1'b0;
        end
        if (load) begin
            rec_d.valid = 1'b1;
            rec_d.len   = len_in;
            rec_d.csum  = csum_in;
            rec_d.stat  = stat_in;
            rec_d.err   = err_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else begin
            rec_q <= rec_d;
        end
    end

    assign busy  = rec_q.valid && !ready;
    assign valid = rec_q.valid;
    assign len   = rec_q.len;
    assign csum  = rec_q.csum;
    assign stat  = rec_q.stat;
    assign err   = rec_q.err;

endmodule

// File: rtl/rx_wb_engine.sv
module rx_wb_engine
    import rxwb_pkg::*;
#(
    parameter int unsigned LEN_W  = 12,
    parameter int unsigned TYPE_W = 16,
    parameter int unsigned ERR_W  = 8,
    parameter int unsigned CSUM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_buf_size,
    input  logic [TYPE_W-1:0] cfg_vlan_type,
    input  logic              cfg_vlan_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [TYPE_W-1:0] sb_frame_type,
    input  logic              sb_ixsm,
    input  logic              sb_ipcs,
    input  logic              sb_tcpcs,
    input  logic              sb_pif,
    input  logic [ERR_W-1:0]  sb_err,
    input  logic [CSUM_W-1:0] sb_csum,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [LEN_W-1:0]  wb_len,
    output logic [CSUM_W-1:0] wb_csum,
    output logic [STAT_W-1:0] wb_status,
    output logic [ERR_W-1:0]  wb_err
);

    logic              acc;
    logic              busy;
    logic              close;
    logic [LEN_W-1:0]  beat_len;
    rx_stat_t          stat_new;
    rx_stat_t          stat_out;
    logic [ERR_W-1:0]  err_new;
    logic [CSUM_W-1:0] csum_new;

    assign in_ready  = !busy;
    assign acc       = in_valid && in_ready;
    assign wb_status = stat_out;

    rxwb_split #(.LEN_W(LEN_W)) u_split (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .sop      (in_sop),
        .eop      (in_eop),
        .buf_size (cfg_buf_size),
        .close    (close),
        .len      (beat_len)
    );

    rxwb_fields #(.TYPE_W(TYPE_W), .ERR_W(ERR_W), .CSUM_W(CSUM_W)) u_fields (
        .last       (in_eop),
        .frame_type (sb_frame_type),
        .vlan_type  (cfg_vlan_type),
        .vlan_en    (cfg_vlan_en),
        .ixsm       (sb_ixsm),
        .ipcs       (sb_ipcs),
        .tcpcs      (sb_tcpcs),
        .pif        (sb_pif),
        .err_in     (sb_err),
        .csum_in    (sb_csum),
        .stat       (stat_new),
        .err_out    (err_new),
        .csum_out   (csum_new)
    );

    rxwb_wb_reg #(.LEN_W(LEN_W), .ERR_W(ERR_W), .CSUM_W(CSUM_W)) u_wb (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (close),
        .len_in  (beat_len),
        .csum_in (csum_new),
        .stat_in (stat_new),
        .err_in  (err_new),
        .ready   (wb_ready),
        .busy    (busy),
        .valid   (wb_valid),
        .len     (wb_len),
        .csum    (wb_csum),
        .stat    (stat_out),
        .err     (wb_err)
    );

endmodule

// File: rtl/rx_wb_engine_chk.sv
module rx_wb_engine_chk #(
    parameter int unsigned LEN_W  = 12,
    parameter int unsigned ERR_W  = 8,
    parameter int unsigned CSUM_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LEN_W-1:0]  cfg_buf_size,
    input logic              in_ready,
    input logic              wb_valid,
    input logic              wb_ready,
    input logic [LEN_W-1:0]  wb_len,
    input logic [CSUM_W-1:0] wb_csum,
    input logic [7:0]        wb_status,
    input logic [ERR_W-1:0]  wb_err
);

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_len) && $stable(wb_status)
                                  && $stable(wb_err) && $stable(wb_csum));

    a_r9_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |-> !in_ready);

    a_r4_done_set: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_status[0]);

    a_r5_nonfinal_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_status[1] |-> wb_status[7:2] == 6'd0 && wb_err == '0 && wb_csum == '0);

    a_r7_ixsm_masks: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && wb_status[2] |-> wb_status[6:5] == 2'b00);

    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !wb_status[4]);

    a_r1_nonfinal_len: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_status[1] |-> wb_len == cfg_buf_size);

    a_r3_nonzero_len: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_len != '0);

endmodule

bind rx_wb_engine rx_wb_engine_chk #(.LEN_W(LEN_W), .ERR_W(ERR_W), .CSUM_W(CSUM_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_buf_size (cfg_buf_size),
    .in_ready     (in_ready),
    .wb_valid     (wb_valid),
    .wb_ready     (wb_ready),
    .wb_len       (wb_len),
    .wb_csum      (wb_csum),
    .wb_status    (wb_status),
    .wb_err       (wb_err)
);

// File: tb/sim_rx_wb_engine.sv
module sim_rx_wb_engine;

    localparam int unsigned LEN_W  = 12;
    localparam int unsigned TYPE_W = 16;
    localparam int unsigned ERR_W  = 8;
    localparam int unsigned CSUM_W = 16;

    typedef struct packed {
        int unsigned flen;
        int unsigned bsz;
        int unsigned n;
        int unsigned last;
    } vec_t;

    // frame length, buffer size, expected record count, expected final length
    localparam vec_t VECS [7] = '{
        '{32'd1,  32'd4,   32'd1, 32'd1},
        '{32'd4,  32'd4,   32'd1, 32'd4},
        '{32'd5,  32'd4,   32'd2, 32'd1},
        '{32'd10, 32'd3,   32'd4, 32'd1},
        '{32'd9,  32'd3,   32'd3, 32'd3},
        '{32'd64, 32'd16,  32'd4, 32'd16},
        '{32'd7,  32'd256, 32'd1, 32'd7}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LEN_W-1:0]  cfg_buf_size = 12'd4;
    logic [TYPE_W-1:0] cfg_vlan_type = 16'h8100;
    logic              cfg_vlan_en = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic              in_sop = 1'b0;
    logic              in_eop = 1'b0;
    logic [TYPE_W-1:0] sb_frame_type = 16'h0800;
    logic              sb_ixsm = 1'b0;
    logic              sb_ipcs = 1'b0;
    logic              sb_tcpcs = 1'b0;
    logic              sb_pif = 1'b0;
    logic [ERR_W-1:0]  sb_err = '0;
    logic [CSUM_W-1:0] sb_csum = '0;
    logic              wb_valid;
    logic              wb_ready = 1'b1;
    logic [LEN_W-1:0]  wb_len;
    logic [CSUM_W-1:0] wb_csum;
    logic [7:0]        wb_status;
    logic [ERR_W-1:0]  wb_err;

    int n_chk = 0;
    int n_err = 0;
    int rec_n = 0;
    int          rec_len  [64];
    logic [7:0]  rec_stat [64];
    int          rec_err  [64];
    int          rec_csum [64];

    always #2 clk = ~clk;

    rx_wb_engine #(.LEN_W(LEN_W), .TYPE_W(TYPE_W), .ERR_W(ERR_W), .CSUM_W(CSUM_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_buf_size(cfg_buf_size),
        .cfg_vlan_type(cfg_vlan_type), .cfg_vlan_en(cfg_vlan_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop),
        .sb_frame_type(sb_frame_type), .sb_ixsm(sb_ixsm), .sb_ipcs(sb_ipcs),
        .sb_tcpcs(sb_tcpcs), .sb_pif(sb_pif), .sb_err(sb_err), .sb_csum(sb_csum),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_len(wb_len), .wb_csum(wb_csum),
        .wb_status(wb_status), .wb_err(wb_err)
    );

    // Record every accepted writeback (handshake completes at the next edge).
    always @(negedge clk) begin
        if (rst_n && wb_valid && wb_ready && rec_n < 64) begin
            rec_len[rec_n]  = int'(wb_len);
            rec_stat[rec_n] = wb_status;
            rec_err[rec_n]  = int'(wb_err);
            rec_csum[rec_n] = int'(wb_csum);
            rec_n = rec_n + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_frame(input int n, input bit with_eop);
        for (int i = 0; i < n; i++) begin
            bit ok;
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_eop   = with_eop && (i == n - 1);
            ok = 1'b0;
            do begin
                @(negedge clk);
                ok = in_ready;
                @(posedge clk);
                #1;
            end while (!ok);
        end
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
    endtask

    task automatic set_sb(input bit ixsm, input bit ipcs, input bit tcpcs, input bit pif,
                          input bit ven, input bit match);
        sb_ixsm       = ixsm;
        sb_ipcs       = ipcs;
        sb_tcpcs      = tcpcs;
        sb_pif        = pif;
        cfg_vlan_en   = ven;
        sb_frame_type = match ? cfg_vlan_type : 16'h0800;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        tick(3);
        // R11: reset state
        check("R11 wb_valid after reset", int'(wb_valid), 0);
        check("R11 in_ready after reset", int'(in_ready), 1);
        rst_n = 1'b1;
        tick(2);

        // Table-driven splitting: R1, R2, R3, R4
        for (int v = 0; v < 7; v++) begin
            set_sb(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            cfg_buf_size = LEN_W'(VECS[v].bsz);
            rec_n = 0;
            tick(1);
            send_frame(int'(VECS[v].flen), 1'b1);
            tick(3);
            check("R3 record count", rec_n, int'(VECS[v].n));
            for (int i = 0; i < rec_n; i++) begin
                check("R4 done bit", int'(rec_stat[i][0]), 1);
                if (i < rec_n - 1) begin
                    check("R1 full buffer length", rec_len[i], int'(VECS[v].bsz));
                    check("R1 eop clear on non-final", int'(rec_stat[i][1]), 0);
                end else begin
                    check("R2 final length", rec_len[i], int'(VECS[v].last));
                    check("R2 eop on final", int'(rec_stat[i][1]), 1);
                end
            end
        end

        // R5, R6, R7, R8: all flags set, VLAN match; 5 bytes over 2-byte buffers
        cfg_buf_size = 12'd2;
        set_sb(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        sb_err  = 8'h5A;
        sb_csum = 16'hBEEF;
        rec_n = 0;
        tick(1);
        send_frame(5, 1'b1);
        tick(3);
        check("R5 record count", rec_n, 3);
        check("R5 non-final status", int'(rec_stat[0]), 8'h01);
        check("R5 non-final err", rec_err[1], 0);
        check("R5 non-final csum", rec_csum[1], 0);
        check("R7 final status all flags", int'(rec_stat[2]), 8'hEB);
        check("R8 final err", rec_err[2], 8'h5A);
        check("R8 final csum", rec_csum[2], 16'hBEEF);

        // R7: ignore-checksum set masks IPCS/TCPCS; R6 VLAN match kept
        cfg_buf_size = 12'd16;
        set_sb(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        rec_n = 0;
        tick(1);
        send_frame(3, 1'b1);
        tick(3);
        check("R7 ixsm masks checksum flags", int'(rec_stat[0]), 8'h0F);

        // R7: ipcs only; R6 VLAN disabled but type matches
        set_sb(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        rec_n = 0;
        tick(1);
        send_frame(3, 1'b1);
        tick(3);
        check("R6 vp clear when disabled", int'(rec_stat[0]), 8'h43);

        // R6: enabled but type mismatch
        set_sb(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        rec_n = 0;
        tick(1);
        send_frame(3, 1'b1);
        tick(3);
        check("R6 vp clear on mismatch", int'(rec_stat[0]), 8'h23);

        // R10: unterminated partial frame followed by a full frame
        set_sb(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        cfg_buf_size = 12'd8;
        rec_n = 0;
        tick(1);
        send_frame(3, 1'b0);
        send_frame(4, 1'b1);
        tick(3);
        check("R10 one record after restart", rec_n, 1);
        check("R10 length counts from sop", rec_len[0], 4);

        // R9: stall while the next beat waits
        cfg_buf_size = 12'd2;
        wb_ready = 1'b0;
        rec_n = 0;
        tick(1);
        fork
            send_frame(3, 1'b1);
            begin
                tick(6);
                check("R9 record held valid", int'(wb_valid), 1);
                check("R9 input stalled", int'(in_ready), 0);
                check("R9 held length", int'(wb_len), 2);
                check("R9 held status", int'(wb_status), 8'h01);
                tick(2);
                check("R9 length still stable", int'(wb_len), 2);
                wb_ready = 1'b1;
            end
        join
        tick(3);
        check("R9 records after release", rec_n, 2);
        check("R9 first record length", rec_len[0], 2);
        check("R9 trailing record length", rec_len[1], 1);
        check("R9 trailing record eop", int'(rec_stat[1][1]), 1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule